// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Control Core

This block is a synthesizable behavioural model of a byte-wide, electrically programmed, light-erased memory together with its control decode. Four plain control pins (an active-low select, an active-low output gate, a flag saying the programming supply is raised, and a flag saying one address line carries a high voltage) choose between reading, gating the outputs off, standby, programming, program inhibit and reading a two-byte identifier. The data path is an 8-bit bus split into an input, an output and an output-drive strobe that an enclosing pad ring or bus model uses as a tri-state enable.

The memory starts with every bit at 1, and a program pulse can only clear bits: the stored byte becomes the old byte ANDed with the written byte. A one-cycle erase input returns the whole array to ones. A pulse only writes if the select stays low for a parameterised number of clock cycles, so a program-verify-retry loop can be driven against it. Read data appears a parameterised number of cycles after a read begins, with 0xFF shown until then. The array depth is the parameter `ADDR_W` (16 gives 65536 bytes; the default is smaller so the array stays light to elaborate).

The bus is pin-like rather than a stream: there is no valid/ready pair and no back-pressure. `data_oe_o` says when the block drives the bus, and a consumer waits the read latency before taking `data_o`.

Top module: `eprom_core`

## Requirements
- R1: After reset every byte of the array reads 0xFF.
- R2: With ce_n_i low, oe_n_i low, vpp_hi_i low and id_hv_i low, data_oe_o is high and, once the latency of R8 has passed, data_o carries the byte stored at addr_i.
- R3: A completed program pulse stores the old byte ANDed with the captured data byte; a 1 bit can never be set by programming.
- R4: With ce_n_i high and vpp_hi_i low the block is in standby: data_oe_o is low whatever oe_n_i and id_hv_i are.
- R5: With ce_n_i low, oe_n_i high and vpp_hi_i low, data_oe_o is low; whenever data_oe_o is low, data_o is 0xFF.
- R6: With vpp_hi_i high, data_oe_o is low; ce_n_i low selects programming (bus is an input) and ce_n_i high inhibits programming, leaving the array unchanged however long it lasts.
- R7: A program pulse starts at the first rising edge that sees ce_n_i low with vpp_hi_i high, capturing addr_i and data_i there; it writes at the first following edge that sees ce_n_i high with vpp_hi_i still high, only if ce_n_i was low for at least MIN_PULSE consecutive edges. A shorter pulse, or vpp_hi_i falling during the pulse, writes nothing.
- R8: In read or identifier mode data_o is 0xFF until READ_LAT rising edges have seen the same mode and addr_i; any change of addr_i or of the identifier selection restarts the count.
- R9: With id_hv_i high, ce_n_i and oe_n_i low and vpp_hi_i low, the block returns an identifier instead of array data: 0x20 when addr_i bit 0 is 0 and 0x3D when it is 1, provided all other address bits (except bit 9, when present) are 0.
- R10: In identifier mode any address with a 1 in a bit other than bit 0 and bit 9 returns 0xFF.
- R11: erase_i high at a rising edge sets every byte to 0xFF from the next cycle on, and wins over a program write completing at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; fills the array with ones |
| erase_i | input | 1 | Whole-array erase to ones |
| ce_n_i | input | 1 | Active-low select; low pulse programs when the supply flag is high |
| oe_n_i | input | 1 | Active-low output gate |
| vpp_hi_i | input | 1 | Programming supply raised |
| id_hv_i | input | 1 | High voltage present on address bit 9; selects identifier read |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Byte to program |
| data_o | output | 8 | Byte read out (0xFF when not driven or not yet valid) |
| data_oe_o | output | 1 | Bus drive strobe for a tri-state buffer |

## Verification
The main function is tried with a table of program-then-read steps: a first write into a blank byte tells a plain store from an AND merge only together with a second write of overlapping data, and a write of all ones after that tells whether a 1 can wrongly be restored. Reads of untouched and last addresses separate address decode faults from data faults, and identifier reads at addresses 0, 1 and two illegal patterns separate the two codes from the invalid response. Directed cases then vary one control pin at a time so that each mode is told apart from its neighbour, and pulses of MIN_PULSE-1 and MIN_PULSE cycles, and one cut short by the supply flag, bracket the write threshold.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_OUT_OFF,
    MODE_READ,
    MODE_ID,
    MODE_PROGRAM,
    MODE_INHIBIT
  } prom_mode_e;

  localparam logic [7:0] BLANK_BYTE = 8'hFF;
  localparam logic [7:0] MAKER_CODE = 8'h20;
  localparam logic [7:0] PART_CODE  = 8'h3D;
  localparam int         HV_ADDR_BIT = 9;

  // Address bits that must be zero during an identifier read.
  function automatic logic [31:0] id_addr_mask(input int aw);
    logic [63:0] full;
    logic [31:0] m;
    full = (64'd1 << aw) - 64'd1;
    m = full[31:0];
    m[0] = 1'b0;
    m[HV_ADDR_BIT] = 1'b0;
    return m;
  endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic       ce_n_i,
  input  logic       oe_n_i,
  input  logic       vpp_hi_i,
  input  logic       id_hv_i,
  output prom_mode_e mode_o
);

  always_comb begin
    if (ce_n_i) begin
      mode_o = vpp_hi_i ? MODE_INHIBIT : MODE_STANDBY;
    end else if (vpp_hi_i) begin
      mode_o = MODE_PROGRAM;
    end else if (oe_n_i) begin
      mode_o = MODE_OUT_OFF;
    end else begin
      mode_o = id_hv_i ? MODE_ID : MODE_READ;
    end
  end

endmodule

// File: rtl/eprom_pulse_timer.sv
module eprom_pulse_timer #(
  parameter int ADDR_W    = 8,
  parameter int MIN_PULSE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_i,
  input  logic              ce_n_i,
  input  logic              vpp_hi_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o
);

  localparam int            CW    = $clog2(MIN_PULSE + 1);
  localparam logic [CW-1:0] MIN_C = CW'(MIN_PULSE);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic          active_q;
  logic [CW-1:0] width_q;
  logic          pulse_low;

  assign pulse_low = !ce_n_i && vpp_hi_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      width_q   <= '0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else if (erase_i) begin
      active_q <= 1'b0;
      width_q  <= '0;
    end else if (!active_q) begin
      if (pulse_low) begin
        active_q  <= 1'b1;
        width_q   <= ONE_C;
        wr_addr_o <= addr_i;
        wr_data_o <= data_i;
      end
    end else if (!pulse_low) begin
      active_q <= 1'b0;
      width_q  <= '0;
    end else if (width_q != MIN_C) begin
      width_q <= width_q + ONE_C;
    end
  end

  // Write at the closing edge: select back high, supply still raised.
  assign wr_en_o = active_q && vpp_hi_i && ce_n_i && (width_q == MIN_C) && !erase_i;

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  // Synchronous fill: reset models the blank state, erase restores it.
  always_ff @(posedge clk) begin
    if (!rst_n || erase_i) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= eprom_pkg::BLANK_BYTE;
    end else if (wr_en_i) begin
      cells[wr_addr_i] <= cells[wr_addr_i] & wr_data_i;
    end
  end

  assign rd_data_o = cells[rd_addr_i];

endmodule

// File: rtl/eprom_read_path.sv
module eprom_read_path
  import eprom_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int READ_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  prom_mode_e        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        arr_data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o
);

  localparam int                LW       = $clog2(READ_LAT + 1);
  localparam logic [LW-1:0]     LAT_C    = LW'(READ_LAT);
  localparam logic [LW-1:0]     ONE_C    = LW'(1);
  localparam logic [31:0]       MASK32   = id_addr_mask(ADDR_W);
  localparam logic [ADDR_W-1:0] ID_MASK  = MASK32[ADDR_W-1:0];

  logic              drive;
  logic              id_sel;
  logic [ADDR_W:0]   key;
  logic [ADDR_W:0]   key_q;
  logic [LW-1:0]     wait_q;
  logic              ready;
  logic [7:0]        id_byte;

  assign drive  = (mode_i == MODE_READ) || (mode_i == MODE_ID);
  assign id_sel = (mode_i == MODE_ID);
  assign key    = {id_sel, addr_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      wait_q <= '0;
    end else begin
      key_q <= key;
      if (!drive) begin
        wait_q <= '0;
      end else if (key != key_q) begin
        wait_q <= ONE_C;
      end else if (wait_q != LAT_C) begin
        wait_q <= wait_q + ONE_C;
      end
    end
  end

  assign ready = drive && (key == key_q) && (wait_q == LAT_C);

  always_comb begin
    if (|(addr_i & ID_MASK)) id_byte = BLANK_BYTE;
    else if (addr_i[0])      id_byte = PART_CODE;
    else                     id_byte = MAKER_CODE;
  end

  assign data_o    = ready ? (id_sel ? id_byte : arr_data_i) : BLANK_BYTE;
  assign data_oe_o = drive;

endmodule

// File: rtl/eprom_core.sv
module eprom_core
  import eprom_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int READ_LAT  = 2,
  parameter int MIN_PULSE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              vpp_hi_i,
  input  logic              id_hv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o
);

  prom_mode_e        mode;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic [7:0]        arr_data;

  eprom_mode_dec u_dec (
    .ce_n_i   (ce_n_i),
    .oe_n_i   (oe_n_i),
    .vpp_hi_i (vpp_hi_i),
    .id_hv_i  (id_hv_i),
    .mode_o   (mode)
  );

  eprom_pulse_timer #(.ADDR_W(ADDR_W), .MIN_PULSE(MIN_PULSE)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .erase_i   (erase_i),
    .ce_n_i    (ce_n_i),
    .vpp_hi_i  (vpp_hi_i),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  eprom_cell_array #(.ADDR_W(ADDR_W)) u_cells (
    .clk       (clk),
    .rst_n     (rst_n),
    .erase_i   (erase_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (addr_i),
    .rd_data_o (arr_data)
  );

  eprom_read_path #(.ADDR_W(ADDR_W), .READ_LAT(READ_LAT)) u_read (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode),
    .addr_i     (addr_i),
    .arr_data_i (arr_data),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o)
  );

endmodule

// File: rtl/eprom_core_chk.sv
module eprom_core_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n_i,
  input logic              oe_n_i,
  input logic              vpp_hi_i,
  input logic              id_hv_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        data_o,
  input logic              data_oe_o
);

  localparam logic [31:0]       M32  = eprom_pkg::id_addr_mask(ADDR_W);
  localparam logic [ADDR_W-1:0] MASK = M32[ADDR_W-1:0];

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n_i && !oe_n_i && !vpp_hi_i) |-> data_oe_o);

  // R4
  standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n_i && !vpp_hi_i) |-> !data_oe_o);

  // R5
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe_o |-> (data_o == 8'hFF));

  // R6
  supply_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_hi_i |-> !data_oe_o);

  // R8
  first_cycle_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe_o) |-> (data_o == 8'hFF));

  // R9
  id_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe_o && id_hv_i && ((addr_i & MASK) == '0) && (data_o != 8'hFF))
      |-> (data_o == (addr_i[0] ? 8'h3D : 8'h20)));

  // R10
  id_bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe_o && id_hv_i && ((addr_i & MASK) != '0)) |-> (data_o == 8'hFF));

endmodule

bind eprom_core eprom_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n_i    (ce_n_i),
  .oe_n_i    (oe_n_i),
  .vpp_hi_i  (vpp_hi_i),
  .id_hv_i   (id_hv_i),
  .addr_i    (addr_i),
  .data_o    (data_o),
  .data_oe_o (data_oe_o)
);

// File: tb/eprom_core_tb.sv
module eprom_core_tb_top;

  localparam int AW  = 8;
  localparam int LAT = 2;
  localparam int MINP = 4;
  localparam int NVEC = 14;

  // op: 0 = program (MINP cycles), 1 = array read, 2 = identifier read
  localparam logic [25:0] VEC [NVEC] = '{
    {2'd0, 8'h10, 8'hA5, 8'h00},
    {2'd1, 8'h10, 8'h00, 8'hA5},
    {2'd0, 8'h10, 8'h3C, 8'h00},
    {2'd1, 8'h10, 8'h00, 8'h24},
    {2'd0, 8'h10, 8'hFF, 8'h00},
    {2'd1, 8'h10, 8'h00, 8'h24},
    {2'd1, 8'h11, 8'h00, 8'hFF},
    {2'd0, 8'hFF, 8'h00, 8'h00},
    {2'd1, 8'hFF, 8'h00, 8'h00},
    {2'd2, 8'h00, 8'h00, 8'h20},
    {2'd2, 8'h01, 8'h00, 8'h3D},
    {2'd2, 8'h02, 8'h00, 8'hFF},
    {2'd2, 8'h81, 8'h00, 8'hFF},
    {2'd1, 8'h00, 8'h00, 8'hFF}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          erase_i = 1'b0;
  logic          ce_n_i = 1'b1;
  logic          oe_n_i = 1'b1;
  logic          vpp_hi_i = 1'b0;
  logic          id_hv_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    data_i = '0;
  logic [7:0]    data_o;
  logic          data_oe_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  eprom_core #(.ADDR_W(AW), .READ_LAT(LAT), .MIN_PULSE(MINP)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .erase_i   (erase_i),
    .ce_n_i    (ce_n_i),
    .oe_n_i    (oe_n_i),
    .vpp_hi_i  (vpp_hi_i),
    .id_hv_i   (id_hv_i),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic go_idle();
    ce_n_i = 1'b1; oe_n_i = 1'b1; vpp_hi_i = 1'b0; id_hv_i = 1'b0;
  endtask

  task automatic do_prog(input logic [7:0] a, input logic [7:0] d, input int len);
    @(negedge clk);
    addr_i = a; data_i = d; vpp_hi_i = 1'b1; ce_n_i = 1'b1; oe_n_i = 1'b1;
    @(negedge clk);
    ce_n_i = 1'b0;
    repeat (len) @(negedge clk);
    ce_n_i = 1'b1;
    @(negedge clk);
    vpp_hi_i = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, input logic id, output logic [7:0] v);
    @(negedge clk);
    addr_i = a; id_hv_i = id; vpp_hi_i = 1'b0; ce_n_i = 1'b0; oe_n_i = 1'b0;
    repeat (LAT) @(negedge clk);
    #1;
    v = data_o;
    go_idle();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check1("R5 reset drive strobe", data_oe_o, 1'b0);
    check8("R5 reset bus value", data_o, 8'hFF);
    do_read(8'h20, 1'b0, v);
    check8("R1 blank after reset", v, 8'hFF);

    // Table of program/read/identifier steps (R2 R3 R9 R10)
    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][25:24])
        2'd0: do_prog(VEC[i][23:16], VEC[i][15:8], MINP);
        2'd1: begin
          do_read(VEC[i][23:16], 1'b0, v);
          check8($sformatf("R2/R3 vector %0d", i), v, VEC[i][7:0]);
        end
        default: begin
          do_read(VEC[i][23:16], 1'b1, v);
          check8($sformatf("R9/R10 vector %0d", i), v, VEC[i][7:0]);
        end
      endcase
    end

    // R4 standby ignores output gate and identifier flag
    @(negedge clk);
    ce_n_i = 1'b1; oe_n_i = 1'b0; vpp_hi_i = 1'b0; id_hv_i = 1'b1; addr_i = 8'h10;
    #1;
    check1("R4 standby strobe", data_oe_o, 1'b0);
    check8("R4 standby bus", data_o, 8'hFF);

    // R5 output gate high
    @(negedge clk);
    ce_n_i = 1'b0; oe_n_i = 1'b1; id_hv_i = 1'b0;
    #1;
    check1("R5 output off strobe", data_oe_o, 1'b0);
    check8("R5 output off bus", data_o, 8'hFF);
    go_idle();

    // R6 inhibit: supply high, select high for many cycles
    @(negedge clk);
    addr_i = 8'h30; data_i = 8'h00; vpp_hi_i = 1'b1; ce_n_i = 1'b1; oe_n_i = 1'b0;
    #1;
    check1("R6 inhibit strobe", data_oe_o, 1'b0);
    repeat (8) @(negedge clk);
    go_idle();
    do_read(8'h30, 1'b0, v);
    check8("R6 inhibit leaves byte", v, 8'hFF);

    // R6 program mode with output gate low does not drive
    @(negedge clk);
    addr_i = 8'h40; data_i = 8'h0F; vpp_hi_i = 1'b1; ce_n_i = 1'b0; oe_n_i = 1'b0;
    #1;
    check1("R6 program strobe", data_oe_o, 1'b0);
    repeat (MINP - 1) @(negedge clk);
    ce_n_i = 1'b1;
    @(negedge clk);
    go_idle();
    do_read(8'h40, 1'b0, v);
    check8("R7 short pulse ignored", v, 8'hFF);
    do_prog(8'h40, 8'h0F, MINP);
    do_read(8'h40, 1'b0, v);
    check8("R7 minimum pulse writes", v, 8'h0F);

    // R7 supply falling mid-pulse aborts
    @(negedge clk);
    addr_i = 8'h41; data_i = 8'h00; vpp_hi_i = 1'b1; ce_n_i = 1'b0;
    repeat (MINP + 1) @(negedge clk);
    vpp_hi_i = 1'b0;
    @(negedge clk);
    ce_n_i = 1'b1;
    @(negedge clk);
    do_read(8'h41, 1'b0, v);
    check8("R7 aborted pulse", v, 8'hFF);

    // R8 latency and restart on address change
    @(negedge clk);
    addr_i = 8'h10; ce_n_i = 1'b0; oe_n_i = 1'b0;
    #1;
    check1("R8 strobe at once", data_oe_o, 1'b1);
    check8("R8 blank at start", data_o, 8'hFF);
    repeat (LAT - 1) @(negedge clk);
    #1;
    check8("R8 blank one short", data_o, 8'hFF);
    @(negedge clk);
    #1;
    check8("R8 data after latency", data_o, 8'h24);
    @(negedge clk);
    addr_i = 8'hFF;
    #1;
    check8("R8 restart on address", data_o, 8'hFF);
    repeat (LAT) @(negedge clk);
    #1;
    check8("R8 new address data", data_o, 8'h00);
    go_idle();

    // R11 erase
    @(negedge clk);
    erase_i = 1'b1;
    @(negedge clk);
    erase_i = 1'b0;
    do_read(8'h10, 1'b0, v);
    check8("R11 erase 0x10", v, 8'hFF);
    do_read(8'hFF, 1'b0, v);
    check8("R11 erase 0xFF", v, 8'hFF);
    do_read(8'h40, 1'b0, v);
    check8("R11 erase 0x40", v, 8'hFF);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule